// File: doc/BRIEF.md
# Burst-of-Two DDR SRAM Datapath

This block is the core datapath of a common-I/O, double-data-rate synchronous SRAM that moves data in bursts of two. Each burst is two half-width beats on consecutive clock phases. On a write, an input demultiplexer gathers both beats into one word that is twice the bus width and commits that word to the storage array in a single operation. Each beat carries its own active-low byte enables, so the two halves of the word can be masked independently. On a read, one double-width word is fetched and an output multiplexer returns it as two beats, two and a half clock periods after the command, with a data-valid strobe beside it.

The block runs on a beat-rate clock `clk`, which is twice the rate of the external K clock. An internal phase register marks which beats fall on a rising K edge, and that phase is exported as `k_rise`. Commands are sampled only on rise beats. Data and byte enables are sampled on every beat. Latencies are therefore counted in beats: one K cycle is two beats, and 2.5 K cycles is five beats.

Because the internal word is double width, the address has one bit fewer than the depth counted in beats. The write pipeline commits every write before any later read samples the array, so a read always returns the data of every write issued on an earlier K cycle.

Top module: `ddr_b2_sram`

## Requirements
- R1: After `rst` falls, `rvalid` and `rdata` are 0. `k_rise` is 1 during the first beat after reset and then toggles on every beat.
- R2: A write command is `wr_en` high on a beat where `k_rise`=1; call that beat t, with address `addr`. Its first data beat is taken at t+2 and stored in word bits [DW-1:0]. Its second data beat is taken at t+3 and stored in bits [2*DW-1:DW]. Both halves land in the same word.
- R3: A read command is `rd_en` high on a rise beat t. The low half of the word is on `rdata` during beat t+5 and the high half during beat t+6, with `rvalid` high on exactly those beats. On every other beat `rvalid` is 0 and `rdata` is all zeros.
- R4: `bw_n` is sampled with each data beat and is active low. Bit j governs bits [j*DW/NB +: DW/NB] of that beat. A bit at 1 leaves that byte of the stored word unchanged, so a write with all enables at 1 changes nothing.
- R5: `rd_en` and `wr_en` are ignored on beats where `k_rise`=0. Such a command produces no read data and changes no stored word.
- R6: Read commands on consecutive rise beats produce a gapless stream of beats with `rvalid` held high throughout.
- R7: A read issued one or more K cycles after a write to the same address returns that write's data. A read issued on the same rise beat as a write to the same address returns the word as it was before that write.
- R8: Sustained traffic with a command on every K cycle is handled correctly: writes, reads, combined read-plus-write cycles, and back-to-back masked writes to one address, whose enabled bytes accumulate.
- R9: The address is $clog2(DEPTH_BEATS)-1 bits wide, and every word address up to the highest is stored separately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-rate clock, two beats per K cycle |
| rst | input | 1 | Synchronous active-high reset |
| k_rise | output | 1 | 1 on beats that correspond to a rising K edge |
| rd_en | input | 1 | Read command, sampled on rise beats |
| wr_en | input | 1 | Write command, sampled on rise beats |
| addr | input | $clog2(DEPTH_BEATS)-1 | Word address for the command |
| wdata | input | DW | Write data beat |
| bw_n | input | NB | Active-low byte enables for the current beat |
| rdata | output | DW | Read data beat, zero when not valid |
| rvalid | output | 1 | High while a valid read beat is on `rdata` |

## Verification
The bench builds the block with an 18-bit bus split into two 9-bit byte lanes and a 32-beat depth. That gives a 4-bit address and 16 words, so one burst of streaming writes followed by one of streaming reads covers every address, including the top one. With only two lanes per beat, the opposite-byte patterns on the two beats, the all-masked write and the accumulation of partial writes can all be checked bit for bit against a reference word model. Scheduling read and write commands on chosen beats reaches same-cycle, next-cycle and falling-phase cases directly.

// File: rtl/ddr_b2_pkg.sv
package ddr_b2_pkg;

  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } kphase_e;

  function automatic int unsigned lane_width(input int unsigned dw, input int unsigned nb);
    return dw / nb;
  endfunction

endpackage

// File: rtl/b2_kphase.sv
module b2_kphase
  import ddr_b2_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output kphase_e ph_o
);

  kphase_e ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_RISE;
    else     ph_q <= (ph_q == PH_RISE) ? PH_FALL : PH_RISE;
  end

  assign ph_o = ph_q;

endmodule

// File: rtl/b2_write_demux.sv
module b2_write_demux
#(
  parameter int unsigned DW = 18,
  parameter int unsigned NB = 2,
  parameter int unsigned AW = 6
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            rise,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NB-1:0]   bw_n,
  output logic [2*NB-1:0] we_lanes,
  output logic [AW-1:0]   waddr,
  output logic [2*DW-1:0] wword
);

  // Two-stage command pipe advanced on rise beats.
  logic          s0_v, s1_v;
  logic [AW-1:0] s0_a, s1_a;
  logic [DW-1:0] beat1_d, beat2_d;
  logic [NB-1:0] beat1_m, beat2_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_v    <= 1'b0;
      s1_v    <= 1'b0;
      s0_a    <= '0;
      s1_a    <= '0;
      beat1_d <= '0;
      beat2_d <= '0;
      beat1_m <= '0;
      beat2_m <= '0;
    end else if (rise) begin
      s0_v <= wr_en;
      s0_a <= addr;
      s1_v <= s0_v;
      s1_a <= s0_a;
      if (s0_v) begin
        beat1_d <= wdata;
        beat1_m <= ~bw_n;
      end
    end else if (s1_v) begin
      beat2_d <= wdata;
      beat2_m <= ~bw_n;
    end
  end

  // Commit the assembled word on the rise beat after the second data beat.
  assign we_lanes = (rise && s1_v) ? {beat2_m, beat1_m} : '0;
  assign waddr    = s1_a;
  assign wword    = {beat2_d, beat1_d};

  // R2: a lane write only follows a write command two K cycles earlier
  p_commit_delay_r2: assert property (@(posedge clk) disable iff (rst)
    (|we_lanes) |-> $past(wr_en && rise, 4));

endmodule

// File: rtl/b2_lane_ram.sv
module b2_lane_ram
#(
  parameter int unsigned W  = 9,
  parameter int unsigned AW = 6
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Read-first single-clock RAM, one write and one read port.
  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
    if (we) mem[waddr] <= wd;
  end

endmodule

// File: rtl/b2_word_array.sv
module b2_word_array
  import ddr_b2_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned NB = 2,
  parameter int unsigned AW = 6
)(
  input  logic            clk,
  input  logic [2*NB-1:0] we_lanes,
  input  logic [AW-1:0]   waddr,
  input  logic [2*DW-1:0] wword,
  input  logic            re,
  input  logic [AW-1:0]   raddr,
  output logic [2*DW-1:0] rword
);

  localparam int unsigned LW    = lane_width(DW, NB);
  localparam int unsigned LANES = 2 * NB;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    b2_lane_ram #(.W(LW), .AW(AW)) u_lane (
      .clk   (clk),
      .we    (we_lanes[j]),
      .waddr (waddr),
      .wd    (wword[j*LW +: LW]),
      .re    (re),
      .raddr (raddr),
      .q     (rword[j*LW +: LW])
    );
  end

endmodule

// File: rtl/b2_read_mux.sv
module b2_read_mux
#(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 6
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            rise,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  output logic            re,
  output logic [AW-1:0]   raddr,
  input  logic [2*DW-1:0] rword,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);

  logic          r0_v, r1_v, hi_pend;
  logic [AW-1:0] r0_a, r1_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      r0_v <= 1'b0;
      r1_v <= 1'b0;
      r0_a <= '0;
      r1_a <= '0;
    end else if (rise) begin
      r0_v <= rd_en;
      r0_a <= addr;
      r1_v <= r0_v;
      r1_a <= r0_a;
    end
  end

  // Array read on the fall beat three beats after the command.
  assign re    = !rise && r1_v;
  assign raddr = r1_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      rvalid  <= 1'b0;
      hi_pend <= 1'b0;
    end else begin
      hi_pend <= rise && r1_v;
      if (rise && r1_v) begin
        rdata  <= rword[DW-1:0];
        rvalid <= 1'b1;
      end else if (hi_pend) begin
        rdata  <= rword[2*DW-1:DW];
        rvalid <= 1'b1;
      end else begin
        rdata  <= '0;
        rvalid <= 1'b0;
      end
    end
  end

  // R3: a burst starts five beats after a read command on a rise beat
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |-> $past(rd_en && rise, 5));

  // R3: every burst carries two beats
  p_pair_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |=> rvalid);

  // R3: first beat of a burst sits on a fall beat
  p_first_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |-> !rise);

  // R3: bus is quiet when no beat is valid
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0));

endmodule

// File: rtl/ddr_b2_sram.sv
module ddr_b2_sram
  import ddr_b2_pkg::*;
#(
  parameter  int unsigned DW          = 18,
  parameter  int unsigned NB          = 2,
  parameter  int unsigned DEPTH_BEATS = 128,
  localparam int unsigned AW          = $clog2(DEPTH_BEATS) - 1
)(
  input  logic          clk,
  input  logic          rst,
  output logic          k_rise,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] bw_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  kphase_e         ph;
  logic            rise;
  logic [2*NB-1:0] we_lanes;
  logic [AW-1:0]   waddr, raddr;
  logic [2*DW-1:0] wword, rword;
  logic            re;

  b2_kphase u_phase (
    .clk  (clk),
    .rst  (rst),
    .ph_o (ph)
  );

  assign rise   = (ph == PH_RISE);
  assign k_rise = rise;

  b2_write_demux #(.DW(DW), .NB(NB), .AW(AW)) u_wdemux (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .bw_n     (bw_n),
    .we_lanes (we_lanes),
    .waddr    (waddr),
    .wword    (wword)
  );

  b2_word_array #(.DW(DW), .NB(NB), .AW(AW)) u_array (
    .clk      (clk),
    .we_lanes (we_lanes),
    .waddr    (waddr),
    .wword    (wword),
    .re       (re),
    .raddr    (raddr),
    .rword    (rword)
  );

  b2_read_mux #(.DW(DW), .AW(AW)) u_rmux (
    .clk    (clk),
    .rst    (rst),
    .rise   (rise),
    .rd_en  (rd_en),
    .addr   (addr),
    .re     (re),
    .raddr  (raddr),
    .rword  (rword),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  // R1: phase alternates every beat out of reset
  p_phase_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    k_rise |=> !k_rise);

endmodule

// File: tb/ddr_b2_sram_bench.sv
`timescale 1ns/1ps
module ddr_b2_sram_bench;

  localparam int unsigned DW          = 18;
  localparam int unsigned NB          = 2;
  localparam int unsigned DEPTH_BEATS = 32;
  localparam int unsigned AW          = $clog2(DEPTH_BEATS) - 1;
  localparam int unsigned LW          = DW / NB;
  localparam int unsigned NW          = 1 << AW;
  localparam int unsigned SL          = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] bw_n = '1;
  logic          k_rise, rvalid;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic          s_rd   [SL];
  logic          s_wr   [SL];
  logic [AW-1:0] s_addr [SL];
  logic [DW-1:0] s_wd   [SL];
  logic [NB-1:0] s_bw   [SL];
  logic [2*DW-1:0] refm [NW];

  always #2.5 clk = ~clk;

  ddr_b2_sram #(.DW(DW), .NB(NB), .DEPTH_BEATS(DEPTH_BEATS)) u_ddr_b2_sram (
    .clk    (clk),
    .rst    (rst),
    .k_rise (k_rise),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .bw_n   (bw_n),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int k, input int b, input int salt);
    return DW'((k + 1) * 32'h1_5A3C ^ (b * 32'h3F0F) ^ (salt * 32'h0_7C1));
  endfunction

  task automatic clear_stim();
    for (int i = 0; i < SL; i++) begin
      s_rd[i] = 1'b0; s_wr[i] = 1'b0; s_addr[i] = '0;
      s_wd[i] = '0;   s_bw[i] = '1;
    end
  endtask

  // Drive a beat schedule from a rise beat, then compare every beat with the model.
  task automatic play(input int n, input string tag);
    logic [DW:0]     got  [SL];
    logic [DW:0]     expc [SL];
    logic [2*DW-1:0] w;
    @(negedge clk);
    while (!k_rise) @(negedge clk);
    for (int i = 0; i < n + 7; i++) begin
      got[i] = {rvalid, rdata};
      if (i < n) begin
        rd_en = s_rd[i]; wr_en = s_wr[i]; addr = s_addr[i];
        wdata = s_wd[i]; bw_n = s_bw[i];
      end else begin
        rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; bw_n = '1;
      end
      @(negedge clk);
    end
    for (int i = 0; i < SL; i++) expc[i] = '0;
    for (int i = 0; i < n; i += 2) begin
      if (s_rd[i]) begin
        w = refm[s_addr[i]];
        expc[i+5] = {1'b1, w[DW-1:0]};
        expc[i+6] = {1'b1, w[2*DW-1:DW]};
      end
      if (s_wr[i]) begin
        w = refm[s_addr[i]];
        for (int b = 0; b < 2; b++)
          for (int j = 0; j < int'(NB); j++)
            if (!s_bw[i+2+b][j]) w[b*DW + j*LW +: LW] = s_wd[i+2+b][j*LW +: LW];
        refm[s_addr[i]] = w;
      end
    end
    for (int i = 0; i < n + 7; i++) chk(tag, got[i], expc[i]);
  endtask

  task automatic t_reset();
    chk("R1 rvalid/rdata", {rvalid, rdata}, '0);
    chk("R1 first beat rise", {{DW{1'b0}}, k_rise}, {{DW{1'b0}}, 1'b1});
    @(negedge clk);
    chk("R1 second beat fall", {{DW{1'b0}}, k_rise}, '0);
    @(negedge clk);
    chk("R1 third beat rise", {{DW{1'b0}}, k_rise}, {{DW{1'b0}}, 1'b1});
  endtask

  task automatic t_fill();
    chk("R9 address width", (DW+1)'($bits(addr)), (DW+1)'(4));
    clear_stim();
    for (int k = 0; k < int'(NW); k++) begin
      s_wr[2*k] = 1'b1; s_addr[2*k] = AW'(k);
      s_wd[2*k+2] = pat(k, 0, 1); s_bw[2*k+2] = '0;
      s_wd[2*k+3] = pat(k, 1, 1); s_bw[2*k+3] = '0;
    end
    play(2*NW + 2, "R2 stream write");
    clear_stim();
    for (int k = 0; k < int'(NW); k++) begin
      s_rd[2*k] = 1'b1; s_addr[2*k] = AW'(NW - 1 - k);
    end
    play(2*NW, "R3 R6 R9 stream read");
  endtask

  task automatic t_mask();
    clear_stim();
    s_wr[0] = 1'b1; s_addr[0] = 3;
    s_wd[2] = pat(3, 0, 2); s_bw[2] = 2'b10;
    s_wd[3] = pat(3, 1, 2); s_bw[3] = 2'b01;
    s_wr[2] = 1'b1; s_addr[2] = 5;
    s_wd[4] = pat(5, 0, 2); s_bw[4] = 2'b11;
    s_wd[5] = pat(5, 1, 2); s_bw[5] = 2'b11;
    s_wr[4] = 1'b1; s_addr[4] = 7;
    s_wd[6] = pat(7, 0, 2); s_bw[6] = 2'b00;
    s_wd[7] = pat(7, 1, 2); s_bw[7] = 2'b11;
    s_rd[10] = 1'b1; s_addr[10] = 3;
    s_rd[12] = 1'b1; s_addr[12] = 5;
    s_rd[14] = 1'b1; s_addr[14] = 7;
    play(16, "R4 byte mask");
  endtask

  task automatic t_fall();
    clear_stim();
    s_wr[1] = 1'b1; s_addr[1] = 2;
    s_wd[3] = pat(2, 0, 3); s_bw[3] = '0;
    s_wd[4] = pat(2, 1, 3); s_bw[4] = '0;
    s_rd[3] = 1'b1; s_addr[3] = 2;
    s_rd[12] = 1'b1; s_addr[12] = 2;
    play(14, "R5 fall-beat command");
  endtask

  task automatic t_coh();
    clear_stim();
    s_wr[0] = 1'b1; s_rd[0] = 1'b1; s_addr[0] = 9;
    s_wd[2] = pat(9, 0, 4); s_bw[2] = '0;
    s_wd[3] = pat(9, 1, 4); s_bw[3] = '0;
    s_rd[2] = 1'b1; s_addr[2] = 9;
    s_wr[4] = 1'b1; s_addr[4] = 9;
    s_wd[6] = pat(9, 0, 5); s_bw[6] = 2'b10;
    s_wd[7] = pat(9, 1, 5); s_bw[7] = 2'b10;
    s_wr[6] = 1'b1; s_rd[6] = 1'b1; s_addr[6] = 9;
    s_wd[8] = pat(9, 0, 6); s_bw[8] = 2'b01;
    s_wd[9] = pat(9, 1, 6); s_bw[9] = 2'b01;
    s_rd[8] = 1'b1; s_addr[8] = 9;
    play(10, "R7 coherency");
  endtask

  task automatic t_mix();
    clear_stim();
    for (int k = 0; k < 8; k++) begin
      s_addr[2*k] = AW'(10 + (k / 2));
      if (k % 2 == 0) begin
        s_wr[2*k] = 1'b1;
        s_wd[2*k+2] = pat(k, 0, 7); s_bw[2*k+2] = AW'(k) % 2 == 0 ? 2'b00 : 2'b01;
        s_wd[2*k+3] = pat(k, 1, 7); s_bw[2*k+3] = 2'b00;
      end else begin
        s_rd[2*k] = 1'b1;
      end
    end
    s_wr[6] = 1'b1;
    s_wd[8] = pat(20, 0, 7); s_bw[8] = 2'b10;
    s_wd[9] = pat(20, 1, 7); s_bw[9] = 2'b01;
    s_rd[16] = 1'b1; s_addr[16] = 11;
    play(18, "R8 mixed traffic");
  endtask

  initial begin
    for (int i = 0; i < int'(NW); i++) refm[i] = '0;
    clear_stim();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill();
    t_mask();
    t_fall();
    t_coh();
    t_mix();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule